// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into one request with a vector address. Four sources feed it. Two are external pins, each with its own edge-polarity select. The third is a single-cycle timer overflow pulse. The fourth is a bank of peripheral request lines, each with its own enable. Events are captured into flag bits of an 8-bit status/enable register, whether or not they are masked. A single global disable bit decides whether any unmasked pending source may raise a request.

When a request is raised, the controller freezes the winning source and its vector until the core acknowledges. On acknowledge it sets the global disable bit and pulses a strobe that tells the core to push its return address. Only the core's return-from-interrupt input clears the global disable bit. A wake-from-sleep output reports enabled pin and peripheral activity, independent of the global disable bit.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the global disable output is 1, and the request, push strobe and wake outputs are 0.
- R2: The INT pin is synchronized and then edge-detected. Its select bit chooses the edge: 1 for rising, 0 for falling. The selected edge sets status bit 4 three clock edges after the pin change, and not after two. The opposite edge sets nothing. Status bit 0 is its enable.
- R3: The timer-clock pin behaves the same way with its own independent edge select. It sets status bit 6, and status bit 2 is its enable.
- R4: A one-cycle timer overflow pulse sets status bit 5 at the next clock edge. Status bit 1 is its enable.
- R5: Flag bits 4 to 6 set on their events even when their enable bit is 0 and the global disable bit is 1.
- R6: Status bit 7 is read-only and combinational. It equals the OR over all peripheral lines of request AND line enable. Status bit 3 is its enable.
- R7: A status write loads bits 3:0 from the written data. For each of flag bits 6:4, a written 0 clears the flag and a written 1 leaves it unchanged. A new event in the same cycle as a clear wins.
- R8: Priority runs highest to lowest: INT pin (vector 0x0008), timer (0x0010), timer-clock pin (0x0018), peripherals (0x0020). A pending source is its flag AND its enable.
- R9: The request rises one cycle after a pending source is seen while the global disable bit is 0. It then stays high, with a constant vector, until acknowledged, even if the flag is cleared in the meantime.
- R10: An acknowledge while the request is high drops the request, sets the global disable bit and pulses the push strobe for exactly one cycle, all at the next clock edge.
- R11: A return-from-interrupt pulse clears the global disable bit at the next edge. A pending source that is still set then raises a new request one cycle later.
- R12: The wake output is high whenever the INT pin source, the timer-clock pin source or the peripheral source is pending. The global disable bit has no effect on it, and the timer source does not wake.
- R13: A mask-all pulse sets the global disable bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_pin_i | input | 1 | External INT pin (asynchronous) |
| tck_pin_i | input | 1 | External timer-clock pin (asynchronous) |
| int_rise_i | input | 1 | INT edge select: 1 rising, 0 falling |
| tck_rise_i | input | 1 | Timer-clock pin edge select: 1 rising, 0 falling |
| tmr_ovf_i | input | 1 | Timer overflow pulse |
| per_flag_i | input | PER_N | Peripheral request flags |
| per_en_i | input | PER_N | Peripheral line enables |
| stat_we_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 7 | Write data for status bits 6:0 |
| mask_all_i | input | 1 | Sets the global disable bit |
| ack_i | input | 1 | Core accepts the request |
| reti_i | input | 1 | Return from interrupt |
| stat_o | output | 8 | Status/enable register |
| gdis_o | output | 1 | Global disable bit |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VEC_W | Vector address |
| push_o | output | 1 | Push-return-address strobe |
| wake_o | output | 1 | Wake-from-sleep |

## Verification
The embedded properties check the acceptance handshake on every cycle. They cover the frozen request and vector while no acknowledge arrives, the disable-and-push reaction to an acknowledge, and the rule that a request never rises while globally disabled. They also check that the global disable bit falls only after a return-from-interrupt, that timer pulses always land in their flag, and that the grant is one-hot. Only the directed scenarios can show some behaviours. These are the synchronizer latency of each pin and its polarity choice, the write-zero-to-clear rule, and the read-only peripheral summary. The same holds for the full priority order across all four vectors and the wake sources.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int SRC_N   = 4;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int PIN_N   = 2;
    localparam int FLAG_N  = 3;
    localparam int EN_N    = 4;
    localparam int FLAG_LO = 4;

    // source order equals priority order (index 0 is highest)
    localparam int SRC_INT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_TCK = 2;
    localparam int SRC_PER = 3;

    typedef struct packed {
        logic [FLAG_N-1:0] flag;   // status bits 6:4 -> {tck, tmr, int}
        logic [EN_N-1:0]   en;     // status bits 3:0
        logic              gdis;
        logic              hold;
        logic [IDX_W-1:0]  idx;
        logic              push;
    } vic_state_t;
endpackage

// File: rtl/vic_pin_edge.sv
module vic_pin_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_i,
    output logic edge_o
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    always_comb begin
        if (rise_i) edge_o =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
        else        edge_o = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];
    end

    // R2: one level transition yields at most one single-cycle pulse
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o && $stable(rise_i) |=> !edge_o || !$stable(rise_i));
endmodule

// File: rtl/vic_per_reduce.sv
module vic_per_reduce #(
    parameter int PER_N = 8
) (
    input  logic [PER_N-1:0] flag_i,
    input  logic [PER_N-1:0] en_i,
    output logic             any_o
);
    logic [PER_N-1:0] masked;

    always_comb begin
        for (int i = 0; i < PER_N; i++) masked[i] = flag_i[i] & en_i[i];
        any_o = |masked;
    end
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     act_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] grant;
    logic [N-1:0] above;

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            if (g == 0) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_rest
                assign above[g] = above[g-1] | act_i[g-1];
            end
            assign grant[g] = act_i[g] & ~above[g];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx_o = IDX_W'(i);
        end
        any_o = |act_i;
    end

    // R8: at most one source wins, and the lowest active index wins
    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any_o == (grant != '0)));
    p_grant_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_i[0] |-> grant[0]);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int              PER_N    = 8,
    parameter int              SYNC_N   = 2,
    parameter int              VEC_W    = 16,
    parameter logic [15:0]     VEC_BASE = 16'h0008,
    parameter logic [15:0]     VEC_STEP = 16'h0008
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_pin_i,
    input  logic             tck_pin_i,
    input  logic             int_rise_i,
    input  logic             tck_rise_i,
    input  logic             tmr_ovf_i,
    input  logic [PER_N-1:0] per_flag_i,
    input  logic [PER_N-1:0] per_en_i,
    input  logic             stat_we_i,
    input  logic [6:0]       stat_wdata_i,
    input  logic             mask_all_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic [7:0]       stat_o,
    output logic             gdis_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             push_o,
    output logic             wake_o
);
    vic_state_t st_d, st_q;

    logic [PIN_N-1:0] pin_lvl, pin_rise, pin_edge;
    logic             per_any;
    logic [SRC_N-1:0] act;
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic [FLAG_N-1:0] evt;
    logic [FLAG_N-1:0] clr;

    assign pin_lvl  = {tck_pin_i, int_pin_i};
    assign pin_rise = {tck_rise_i, int_rise_i};

    generate
        for (genvar g = 0; g < PIN_N; g++) begin : g_pin
            vic_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (pin_lvl[g]),
                .rise_i (pin_rise[g]),
                .edge_o (pin_edge[g])
            );
        end
    endgenerate

    vic_per_reduce #(.PER_N(PER_N)) u_per (
        .flag_i (per_flag_i),
        .en_i   (per_en_i),
        .any_o  (per_any)
    );

    always_comb begin
        act[SRC_INT] = st_q.flag[0] & st_q.en[0];
        act[SRC_TMR] = st_q.flag[1] & st_q.en[1];
        act[SRC_TCK] = st_q.flag[2] & st_q.en[2];
        act[SRC_PER] = per_any      & st_q.en[3];
    end

    vic_prio_arb #(.N(SRC_N), .IDX_W(IDX_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .act_i (act),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;

        evt = {pin_edge[1], tmr_ovf_i, pin_edge[0]};
        clr = '0;
        if (stat_we_i) begin
            st_d.en = stat_wdata_i[EN_N-1:0];
            clr     = ~stat_wdata_i[FLAG_LO+FLAG_N-1:FLAG_LO];
        end
        st_d.flag = (st_q.flag & ~clr) | evt;

        if (reti_i) st_d.gdis = 1'b0;

        if (st_q.hold) begin
            if (ack_i) begin
                st_d.hold = 1'b0;
                st_d.gdis = 1'b1;
                st_d.push = 1'b1;
            end
        end else if (!st_q.gdis && win_any) begin
            st_d.hold = 1'b1;
            st_d.idx  = win_idx;
        end

        if (mask_all_i) st_d.gdis = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gdis <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = {per_any, st_q.flag, st_q.en};
    assign gdis_o = st_q.gdis;
    assign irq_o  = st_q.hold;
    assign vec_o  = VEC_W'(VEC_BASE + VEC_STEP * 16'(st_q.idx));
    assign push_o = st_q.push;
    assign wake_o = act[SRC_INT] | act[SRC_TCK] | act[SRC_PER];

    // R9: a raised request holds with a steady vector until acknowledged
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !ack_i |=> irq_o && $stable(vec_o));
    // R9: a request only rises out of the enabled state
    p_raise_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !$past(gdis_o));
    // R10: acceptance disables, strobes push and drops the request
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ack_i |=> gdis_o && push_o && !irq_o);
    p_push_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
    // R11: the global disable bit falls only after return-from-interrupt
    p_gdis_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gdis_o) |-> $past(reti_i));
    // R4 and R5: a timer pulse always lands in its flag
    p_tmr_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_i |=> stat_o[5]);
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    localparam int PER_N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_pin = 0, tck_pin = 0, int_rise = 0, tck_rise = 0, tmr_ovf = 0;
    logic [PER_N-1:0] per_flag = '0, per_en = '0;
    logic stat_we = 0;
    logic [6:0] stat_wdata = '0;
    logic mask_all = 0, ack = 0, reti = 0;
    logic [7:0] stat;
    logic gdis, irq, push, wake;
    logic [15:0] vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vec_irq_ctrl #(.PER_N(PER_N)) uut (
        .clk(clk), .rst_n(rst_n),
        .int_pin_i(int_pin), .tck_pin_i(tck_pin),
        .int_rise_i(int_rise), .tck_rise_i(tck_rise),
        .tmr_ovf_i(tmr_ovf), .per_flag_i(per_flag), .per_en_i(per_en),
        .stat_we_i(stat_we), .stat_wdata_i(stat_wdata),
        .mask_all_i(mask_all), .ack_i(ack), .reti_i(reti),
        .stat_o(stat), .gdis_o(gdis), .irq_o(irq), .vec_o(vec),
        .push_o(push), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] d);
        stat_we = 1; stat_wdata = d; tick(1); stat_we = 0;
    endtask

    task automatic pulse_reti();
        reti = 1; tick(1); reti = 0;
    endtask

    task automatic accept();
        ack = 1; tick(1); ack = 0;
        chk("R10 irq dropped", 32'(irq), 0);
        chk("R10 gdis set", 32'(gdis), 1);
        chk("R10 push pulse", 32'(push), 1);
        tick(1);
        chk("R10 push single", 32'(push), 0);
    endtask

    task automatic t_reset();
        chk("R1 stat", 32'(stat), 0);
        chk("R1 gdis", 32'(gdis), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 push", 32'(push), 0);
        chk("R1 wake", 32'(wake), 0);
    endtask

    task automatic t_int_pin();
        int_rise = 1; int_pin = 1; tick(2);
        chk("R2 not yet after two edges", 32'(stat[4]), 0);
        tick(1);
        chk("R2 rising sets bit4", 32'(stat[4]), 1);
        chk("R5 masked, disabled, no irq", 32'(irq), 0);
        wr(7'h00);
        chk("R7 write 0 clears bit4", 32'(stat[4]), 0);
        int_rise = 0; int_pin = 0; tick(3);
        chk("R2 falling sets bit4", 32'(stat[4]), 1);
        wr(7'h00);
        int_pin = 1; tick(3);
        chk("R2 rising ignored in falling mode", 32'(stat[4]), 0);
        int_pin = 0; tick(3); wr(7'h00);
    endtask

    task automatic t_tck_pin();
        tck_rise = 0; tck_pin = 1; tick(3);
        chk("R3 rising ignored in falling mode", 32'(stat[6]), 0);
        tck_pin = 0; tick(3);
        chk("R3 falling sets bit6", 32'(stat[6]), 1);
        wr(7'h00);
        chk("R3 cleared", 32'(stat[6]), 0);
    endtask

    task automatic t_tmr_and_write();
        tmr_ovf = 1; tick(1); tmr_ovf = 0;
        chk("R4 timer sets bit5", 32'(stat), 32'h20);
        wr(7'h7F);
        chk("R7 write 1 keeps flag, loads enables", 32'(stat), 32'h2F);
        wr(7'h0F);
        chk("R7 write 0 clears flag", 32'(stat), 32'h0F);
        wr(7'h00);
        chk("R7 enables cleared", 32'(stat), 0);
    endtask

    task automatic t_periph();
        per_flag = 8'b0000_0101; per_en = 8'b0000_0010; #1;
        chk("R6 no matching enable", 32'(stat[7]), 0);
        per_en = 8'b0000_0100; #1;
        chk("R6 flag AND enable", 32'(stat[7]), 1);
        tick(0);
        wr(7'h00);
        chk("R6 read-only after write", 32'(stat[7]), 1);
        per_flag = '0; per_en = '0; tick(1);
    endtask

    task automatic t_priority();
        wr(7'h0F);
        per_flag = 8'h01; per_en = 8'h01;
        tmr_ovf = 1; tick(1); tmr_ovf = 0;
        chk("R5 pending but disabled", 32'(irq), 0);
        chk("R8 status", 32'(stat), 32'hAF);
        pulse_reti();
        chk("R11 gdis cleared", 32'(gdis), 0);
        chk("R9 not same cycle", 32'(irq), 0);
        tick(1);
        chk("R9 irq raised", 32'(irq), 1);
        chk("R8 timer beats peripheral", 32'(vec), 32'h0010);
        wr(7'h0F);
        tick(2);
        chk("R9 held after flag clear", 32'(irq), 1);
        chk("R9 vector stable", 32'(vec), 32'h0010);
        accept();
        pulse_reti();
        tick(1);
        chk("R11 re-request", 32'(irq), 1);
        chk("R8 peripheral vector", 32'(vec), 32'h0020);
        accept();
        per_flag = '0; per_en = '0;
        int_rise = 1; tck_rise = 1; int_pin = 1; tck_pin = 1; tick(3);
        chk("R2 R3 both flags", 32'(stat), 32'h5F);
        pulse_reti(); tick(1);
        chk("R8 INT highest", 32'(vec), 32'h0008);
        accept();
        wr(7'h6F);
        chk("R7 selective clear", 32'(stat), 32'h4F);
        pulse_reti(); tick(1);
        chk("R8 timer-clock pin vector", 32'(vec), 32'h0018);
        accept();
        wr(7'h00);
    endtask

    task automatic t_mask();
        pulse_reti();
        chk("R11 gdis clear", 32'(gdis), 0);
        mask_all = 1; tick(1); mask_all = 0;
        chk("R13 mask-all sets gdis", 32'(gdis), 1);
    endtask

    task automatic t_wake();
        tmr_ovf = 1; tick(1); tmr_ovf = 0;
        wr(7'h22);
        chk("R12 timer does not wake", 32'(wake), 0);
        per_flag = 8'h80; per_en = 8'h80;
        wr(7'h08);
        chk("R12 peripheral wakes while disabled", 32'(wake), 1);
        chk("R12 no irq while disabled", 32'(irq), 0);
        per_flag = '0; per_en = '0; #1;
        chk("R12 wake drops", 32'(wake), 0);
        tick(0); wr(7'h00);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        tick(1);
        t_reset();
        t_int_pin();
        t_tck_pin();
        t_tmr_and_write();
        t_periph();
        t_priority();
        t_mask();
        t_wake();
        done = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule